// File: doc/BRIEF.md
# Byte-Wide File Register ALU

This block is the execution stage of an 8-bit accumulator machine. Each cycle that an operation is issued, it combines a working register value, a file register operand and an incoming carry according to a 5-bit operation code. One clock edge later it presents the 8-bit result, a write-back target and an updated five-flag status word. The target is either the working register or the file register.

The operations fall into classes: arithmetic (add, add with carry, three subtract forms, increment, decrement, negate), logic and move, rotates with and without carry, and the flag-neutral group (nibble swap, fill with ones, store working register, counting variants for skip loops, bit clear, set and toggle). Each class writes only its own subset of the status flags. The other flags keep the value held in the block's status register. Instruction fetch, addressing and memory lie outside the block. The caller decodes its instruction word into the operation code, destination bit and bit index.

Top module: `byte_alu`

## Requirements
- R1: Arithmetic results: code 0 gives w+f, 1 gives w+f+carry_in, 5 and 21 give f+1, 6 and 22 give f-1, 7 gives 0-f. flags[0] (C) is the carry out of bit 7 of the add, or for any subtraction the inverted borrow (1 = no borrow). flags[1] (DC) is the same rule applied at bit 3.
- R2: Codes 0 to 7 update all five flags. flags[3] (OV) is the signed two's-complement overflow. flags[4] (N) is result bit 7. flags[2] (Z) is 1 exactly when the result is zero.
- R3: Codes 8 (w AND f), 9 (w OR f), 10 (w XOR f), 11 (NOT f) and 12 (f) update only Z and N.
- R4: Code 13 gives {f[6:0],carry_in} with C=f[7]. Code 14 gives {carry_in,f[7:1]} with C=f[0]. Both update C, Z and N. Code 15 rotates f left and code 16 rotates f right without carry, and both update only Z and N.
- R5: Code 17 (swap nibbles of f), 18 (result 8'hFF), 19 (result w), 21, 22 and the unused codes 26 to 31 (result f) leave all flags unchanged.
- R6: Code 20 gives result 0, sets Z to 1 and leaves C, DC, OV and N unchanged.
- R7: Bit operations leave all flags unchanged and act on bit bit_sel of f. Code 25 (low nibble 1001) clears the bit, code 24 (1000) sets it and code 23 (0111) inverts it.
- R8: Code 2 gives f-w. Code 3 gives f-w-(1-carry_in). Code 4 gives w-f-(1-carry_in).
- R9: res_to_file equals dest_sel (0 = working register, 1 = file register). Codes 7, 18, 19, 20 and 23 to 25 always target the file register.
- R10: An operation issued with op_valid high appears on res_data, res_to_file and flags after exactly one rising edge, with res_valid high in that cycle. With op_valid low, res_valid drops and res_data and flags hold.
- R11: Synchronous active-high reset clears res_valid, res_data, res_to_file and flags to zero. Reset takes priority over an issued operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 5 | Operation select |
| dest_sel | input | 1 | Write-back target: 0 working register, 1 file register |
| bit_sel | input | 3 | Bit index for bit operations |
| wreg_in | input | 8 | Working register value |
| file_in | input | 8 | File register operand |
| carry_in | input | 1 | Incoming carry (1 = no borrow for subtraction) |
| res_valid | output | 1 | Result presented this cycle |
| res_data | output | 8 | Result byte |
| res_to_file | output | 1 | Write-back target of res_data |
| flags | output | 5 | Status {N, OV, Z, DC, C} |

## Verification
The bench targets the carry edges: decrement of zero, negate of zero and of 8'h80, and increments that wrap or cross into the sign bit. A borrow that was not inverted would show C and DC reversed in these cases, and a wrong overflow term would miss 8'h80-1 and 8'h3A+8'h46. Both subtract-with-borrow orders run with each carry value, so swapped operands or a misread borrow would give a different byte. Flag retention is checked by running flag-neutral, logic and clear operations after arithmetic has left non-zero flags. A mask that is too wide would clear or overwrite C, DC or OV there.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBB  = 5'd3,
        OP_RSUBB = 5'd4,
        OP_INC   = 5'd5,
        OP_DEC   = 5'd6,
        OP_NEG   = 5'd7,
        OP_AND   = 5'd8,
        OP_IOR   = 5'd9,
        OP_XOR   = 5'd10,
        OP_COM   = 5'd11,
        OP_MOVF  = 5'd12,
        OP_RLC   = 5'd13,
        OP_RRC   = 5'd14,
        OP_RLN   = 5'd15,
        OP_RRN   = 5'd16,
        OP_SWAP  = 5'd17,
        OP_SETF  = 5'd18,
        OP_MOVW  = 5'd19,
        OP_CLR   = 5'd20,
        OP_INCS  = 5'd21,
        OP_DECS  = 5'd22,
        OP_BTG   = 5'd23,
        OP_BSF   = 5'd24,
        OP_BCF   = 5'd25
    } alu_op_e;

    // status word, bit 4 down to bit 0
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    localparam flags_t MASK_ALL  = '{n: 1'b1, ov: 1'b1, z: 1'b1, dc: 1'b1, c: 1'b1};
    localparam flags_t MASK_ZN   = '{n: 1'b1, ov: 1'b0, z: 1'b1, dc: 1'b0, c: 1'b0};
    localparam flags_t MASK_CZN  = '{n: 1'b1, ov: 1'b0, z: 1'b1, dc: 1'b0, c: 1'b1};
    localparam flags_t MASK_Z    = '{n: 1'b0, ov: 1'b0, z: 1'b1, dc: 1'b0, c: 1'b0};
    localparam flags_t MASK_NONE = '0;

    // operations whose result comes from the adder
    function automatic logic uses_adder(alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUBB,
            OP_INC, OP_DEC, OP_NEG, OP_INCS, OP_DECS: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // which status bits an operation is allowed to write
    function automatic flags_t flag_mask(alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUBB,
            OP_INC, OP_DEC, OP_NEG:                     return MASK_ALL;
            OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOVF,
            OP_RLN, OP_RRN:                             return MASK_ZN;
            OP_RLC, OP_RRC:                             return MASK_CZN;
            OP_CLR:                                     return MASK_Z;
            default:                                    return MASK_NONE;
        endcase
    endfunction

    // operations without a destination choice write the file register
    function automatic logic forces_file(alu_op_e op);
        case (op)
            OP_NEG, OP_SETF, OP_MOVW, OP_CLR,
            OP_BTG, OP_BSF, OP_BCF: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   wval,
    input  logic [DATA_W-1:0]   fval,
    input  logic                cin,
    output logic [DATA_W-1:0]   sum,
    output logic                c_out,
    output logic                dc_out,
    output logic                ov_out
);

    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic              ci;
    logic [DATA_W:0]   full;
    logic [HALF_W:0]   low;

    // every form is opa + opb + ci; subtraction feeds the inverted subtrahend
    always_comb begin
        opa = fval;
        opb = '0;
        ci  = 1'b0;
        case (op)
            OP_ADD:           begin opa = wval; opb = fval;  ci = 1'b0; end
            OP_ADDC:          begin opa = wval; opb = fval;  ci = cin;  end
            OP_SUB:           begin opa = fval; opb = ~wval; ci = 1'b1; end
            OP_SUBB:          begin opa = fval; opb = ~wval; ci = cin;  end
            OP_RSUBB:         begin opa = wval; opb = ~fval; ci = cin;  end
            OP_INC, OP_INCS:  begin opa = fval; opb = '0;    ci = 1'b1; end
            OP_DEC, OP_DECS:  begin opa = fval; opb = '1;    ci = 1'b0; end
            OP_NEG:           begin opa = '0;   opb = ~fval; ci = 1'b1; end
            default:          begin opa = fval; opb = '0;    ci = 1'b0; end
        endcase
    end

    assign full   = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, ci};
    assign low    = {1'b0, opa[HALF_W-1:0]} + {1'b0, opb[HALF_W-1:0]} + {{HALF_W{1'b0}}, ci};
    assign sum    = full[DATA_W-1:0];
    assign c_out  = full[DATA_W];
    assign dc_out = low[HALF_W];
    assign ov_out = (opa[DATA_W-1] == opb[DATA_W-1]) && (full[DATA_W-1] != opa[DATA_W-1]);

endmodule

// File: rtl/alu_shuffle.sv
module alu_shuffle
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int BSEL_W = $clog2(DATA_W)
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   wval,
    input  logic [DATA_W-1:0]   fval,
    input  logic                cin,
    input  logic [BSEL_W-1:0]   bsel,
    output logic [DATA_W-1:0]   res,
    output logic                c_rot
);

    logic [DATA_W-1:0] onehot;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bitdec
        assign onehot[i] = (bsel == BSEL_W'(i));
    end

    always_comb begin
        res = fval;
        case (op)
            OP_AND:  res = wval & fval;
            OP_IOR:  res = wval | fval;
            OP_XOR:  res = wval ^ fval;
            OP_COM:  res = ~fval;
            OP_MOVF: res = fval;
            OP_RLC:  res = {fval[DATA_W-2:0], cin};
            OP_RRC:  res = {cin, fval[DATA_W-1:1]};
            OP_RLN:  res = {fval[DATA_W-2:0], fval[DATA_W-1]};
            OP_RRN:  res = {fval[0], fval[DATA_W-1:1]};
            OP_SWAP: res = {fval[HALF_W-1:0], fval[DATA_W-1:HALF_W]};
            OP_SETF: res = '1;
            OP_MOVW: res = wval;
            OP_CLR:  res = '0;
            OP_BTG:  res = fval ^ onehot;
            OP_BSF:  res = fval | onehot;
            OP_BCF:  res = fval & ~onehot;
            default: res = fval;
        endcase
    end

    always_comb begin
        case (op)
            OP_RLC:  c_rot = fval[DATA_W-1];
            OP_RRC:  c_rot = fval[0];
            default: c_rot = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flagsel.sv
module alu_flagsel
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   add_sum,
    input  logic                add_c,
    input  logic                add_dc,
    input  logic                add_ov,
    input  logic [DATA_W-1:0]   shf_res,
    input  logic                shf_c,
    input  flags_t              old_flags,
    output logic [DATA_W-1:0]   result,
    output flags_t              new_flags
);

    flags_t cand;
    flags_t mask;
    logic   from_adder;

    assign from_adder = uses_adder(op);
    assign mask       = flag_mask(op);
    assign result     = from_adder ? add_sum : shf_res;

    always_comb begin
        cand.c  = from_adder ? add_c : shf_c;
        cand.dc = add_dc;
        cand.ov = add_ov;
        cand.z  = (result == '0);
        cand.n  = result[DATA_W-1];
    end

    assign new_flags = (cand & mask) | (old_flags & ~mask);

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BSEL_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [4:0]          op_code,
    input  logic                dest_sel,
    input  logic [BSEL_W-1:0]   bit_sel,
    input  logic [DATA_W-1:0]   wreg_in,
    input  logic [DATA_W-1:0]   file_in,
    input  logic                carry_in,
    output logic                res_valid,
    output logic [DATA_W-1:0]   res_data,
    output logic                res_to_file,
    output logic [4:0]          flags
);

    alu_op_e           op;
    logic [DATA_W-1:0] add_sum;
    logic              add_c;
    logic              add_dc;
    logic              add_ov;
    logic [DATA_W-1:0] shf_res;
    logic              shf_c;
    logic [DATA_W-1:0] nxt_res;
    flags_t            nxt_flags;
    flags_t            flags_q;

    assign op = alu_op_e'(op_code);

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op     (op),
        .wval   (wreg_in),
        .fval   (file_in),
        .cin    (carry_in),
        .sum    (add_sum),
        .c_out  (add_c),
        .dc_out (add_dc),
        .ov_out (add_ov)
    );

    alu_shuffle #(.DATA_W(DATA_W)) u_shuffle (
        .op    (op),
        .wval  (wreg_in),
        .fval  (file_in),
        .cin   (carry_in),
        .bsel  (bit_sel),
        .res   (shf_res),
        .c_rot (shf_c)
    );

    alu_flagsel #(.DATA_W(DATA_W)) u_flagsel (
        .op        (op),
        .add_sum   (add_sum),
        .add_c     (add_c),
        .add_dc    (add_dc),
        .add_ov    (add_ov),
        .shf_res   (shf_res),
        .shf_c     (shf_c),
        .old_flags (flags_q),
        .result    (nxt_res),
        .new_flags (nxt_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_to_file <= 1'b0;
            flags_q     <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_data    <= nxt_res;
                res_to_file <= dest_sel | forces_file(op);
                flags_q     <= nxt_flags;
            end
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/alu_checker.sv
module alu_checker
    import alu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [4:0] op_code,
    input logic       res_valid,
    input logic [7:0] res_data,
    input logic       res_to_file,
    input logic [4:0] flags
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!res_valid && res_data == 8'h00 && !res_to_file && flags == 5'b0)); // R11

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(res_data) && $stable(flags))); // R10

    AST_ARITH_ZN: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code <= 5'd7) |=> (flags[2] == (res_data == 8'h00) && flags[4] == res_data[7])); // R2

    AST_LOGIC_ZN: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 5'd8 && op_code <= 5'd12)
        |=> (flags[2] == (res_data == 8'h00) && flags[4] == res_data[7]
             && $stable(flags[3]) && $stable(flags[1:0]))); // R3

    AST_ROT_PLAIN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_RLN || op_code == OP_RRN))
        |=> ($stable(flags[3]) && $stable(flags[1:0]))); // R4

    AST_NEUTRAL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_SWAP || op_code == OP_SETF || op_code == OP_MOVW
                      || op_code == OP_INCS || op_code == OP_DECS || op_code >= 5'd26))
        |=> $stable(flags)); // R5

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CLR)
        |=> (res_data == 8'h00 && flags[2] && $stable(flags[4:3]) && $stable(flags[1:0]))); // R6

    AST_BITOP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 5'd23 && op_code <= 5'd25) |=> $stable(flags)); // R7

    AST_FORCED_FILE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_NEG || op_code == OP_SETF || op_code == OP_MOVW
                      || op_code == OP_CLR || (op_code >= 5'd23 && op_code <= 5'd25)))
        |=> res_to_file); // R9

endmodule

bind byte_alu alu_checker i_alu_checker (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_to_file (res_to_file),
    .flags       (flags)
);

// File: tb/test_byte_alu.sv
`timescale 1ns/1ps
module test_byte_alu;
    import alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic       dest_sel = 1'b0;
    logic [2:0] bit_sel = '0;
    logic [7:0] wreg_in = '0;
    logic [7:0] file_in = '0;
    logic       carry_in = 1'b0;
    logic       res_valid;
    logic [7:0] res_data;
    logic       res_to_file;
    logic [4:0] flags;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    byte_alu i_byte_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .dest_sel(dest_sel), .bit_sel(bit_sel), .wreg_in(wreg_in),
        .file_in(file_in), .carry_in(carry_in), .res_valid(res_valid),
        .res_data(res_data), .res_to_file(res_to_file), .flags(flags)
    );

    typedef struct packed {
        logic [4:0] op;
        logic       dst;
        logic [2:0] bsel;
        logic [7:0] w;
        logic [7:0] f;
        logic       cin;
        logic [7:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{5'd0,  1'b0, 3'd0, 8'h3A, 8'h46, 1'b0, 8'h80, 4'd2},  // R2 overflow into sign
        '{5'd0,  1'b1, 3'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 4'd1},  // R1 carry out, zero
        '{5'd1,  1'b0, 3'd0, 8'h0F, 8'h00, 1'b1, 8'h10, 4'd1},  // R1 digit carry
        '{5'd2,  1'b1, 3'd0, 8'h07, 8'h05, 1'b0, 8'hFE, 4'd8},  // R8 borrow
        '{5'd2,  1'b0, 3'd0, 8'h01, 8'h80, 1'b0, 8'h7F, 4'd8},  // R8 signed overflow
        '{5'd3,  1'b0, 3'd0, 8'h01, 8'h10, 1'b0, 8'h0E, 4'd8},  // R8 f-w with borrow
        '{5'd3,  1'b0, 3'd0, 8'h01, 8'h10, 1'b1, 8'h0F, 4'd8},  // R8 f-w no borrow
        '{5'd4,  1'b0, 3'd0, 8'h10, 8'h01, 1'b0, 8'h0E, 4'd8},  // R8 w-f with borrow
        '{5'd4,  1'b1, 3'd0, 8'h01, 8'h10, 1'b1, 8'hF1, 4'd8},  // R8 w-f negative
        '{5'd5,  1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 8'h00, 4'd1},  // R1 increment wrap
        '{5'd5,  1'b1, 3'd0, 8'h00, 8'h7F, 1'b0, 8'h80, 4'd2},  // R2 increment into sign
        '{5'd6,  1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 8'hFF, 4'd1},  // R1 decrement of zero
        '{5'd6,  1'b0, 3'd0, 8'h00, 8'h01, 1'b0, 8'h00, 4'd1},  // R1 decrement to zero
        '{5'd6,  1'b0, 3'd0, 8'h00, 8'h80, 1'b0, 8'h7F, 4'd2},  // R2 decrement overflow
        '{5'd7,  1'b0, 3'd0, 8'h00, 8'h80, 1'b0, 8'h80, 4'd9},  // R9 negate, forced file
        '{5'd7,  1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 4'd1},  // R1 negate zero
        '{5'd7,  1'b1, 3'd0, 8'h00, 8'h01, 1'b0, 8'hFF, 4'd1},  // R1 negate one
        '{5'd0,  1'b0, 3'd0, 8'h88, 8'h88, 1'b0, 8'h10, 4'd2},  // R2 sets C DC OV
        '{5'd8,  1'b0, 3'd0, 8'hF0, 8'h0F, 1'b0, 8'h00, 4'd3},  // R3 AND
        '{5'd9,  1'b1, 3'd0, 8'hA0, 8'h05, 1'b0, 8'hA5, 4'd3},  // R3 OR
        '{5'd10, 1'b0, 3'd0, 8'hFF, 8'h5A, 1'b0, 8'hA5, 4'd3},  // R3 XOR
        '{5'd11, 1'b0, 3'd0, 8'h00, 8'h5A, 1'b0, 8'hA5, 4'd3},  // R3 complement
        '{5'd12, 1'b0, 3'd0, 8'hFF, 8'h00, 1'b0, 8'h00, 4'd3},  // R3 move f
        '{5'd13, 1'b0, 3'd0, 8'h00, 8'h81, 1'b0, 8'h02, 4'd4},  // R4 rotate left via C
        '{5'd14, 1'b1, 3'd0, 8'h00, 8'h01, 1'b1, 8'h80, 4'd4},  // R4 rotate right via C
        '{5'd15, 1'b0, 3'd0, 8'h00, 8'h81, 1'b0, 8'h03, 4'd4},  // R4 plain rotate left
        '{5'd16, 1'b0, 3'd0, 8'h00, 8'h01, 1'b1, 8'h80, 4'd4},  // R4 plain rotate right
        '{5'd17, 1'b0, 3'd0, 8'h00, 8'h3C, 1'b0, 8'hC3, 4'd5},  // R5 swap
        '{5'd18, 1'b0, 3'd0, 8'h00, 8'h12, 1'b0, 8'hFF, 4'd5},  // R5 fill ones
        '{5'd19, 1'b0, 3'd0, 8'h00, 8'h77, 1'b0, 8'h00, 4'd5},  // R5 store w
        '{5'd21, 1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 8'h00, 4'd5},  // R5 skip-increment
        '{5'd22, 1'b1, 3'd0, 8'h00, 8'h00, 1'b0, 8'hFF, 4'd5},  // R5 skip-decrement
        '{5'd31, 1'b0, 3'd0, 8'h00, 8'h42, 1'b0, 8'h42, 4'd5},  // R5 unused code
        '{5'd20, 1'b0, 3'd0, 8'h00, 8'h55, 1'b0, 8'h00, 4'd6},  // R6 clear
        '{5'd25, 1'b0, 3'd7, 8'h00, 8'hFF, 1'b0, 8'h7F, 4'd7},  // R7 clear bit 7
        '{5'd24, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h01, 4'd7},  // R7 set bit 0
        '{5'd23, 1'b0, 3'd3, 8'h00, 8'h0F, 1'b0, 8'h07, 4'd7},  // R7 toggle bit 3
        '{5'd23, 1'b0, 3'd4, 8'h00, 8'h0F, 1'b0, 8'h1F, 4'd7}   // R7 toggle bit 4
    };

    logic [4:0] exp_flags = '0;
    logic [7:0] last_res = '0;

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // independent reference: integer arithmetic, flags in order {N,OV,Z,DC,C}
    function automatic void ref_model(input logic [4:0] op, input logic dst, input logic [2:0] b,
                                      input logic [7:0] w, input logic [7:0] f, input logic cin,
                                      inout logic [4:0] fl, output logic [7:0] r, output logic tofile);
        int x, y, k, s, lo, sv;
        logic is_sub;
        logic c, dc, ov;
        logic [4:0] m;
        logic [4:0] cand;
        x = 0; y = 0; k = 0; is_sub = 1'b0;
        c = 1'b0; dc = 1'b0; ov = 1'b0; m = 5'b00000; r = f;
        case (op)
            5'd0:  begin x = w; y = f; k = 0;       m = 5'b11111; end
            5'd1:  begin x = w; y = f; k = cin;     m = 5'b11111; end
            5'd2:  begin x = f; y = w; k = 0;       is_sub = 1'b1; m = 5'b11111; end
            5'd3:  begin x = f; y = w; k = 1 - cin; is_sub = 1'b1; m = 5'b11111; end
            5'd4:  begin x = w; y = f; k = 1 - cin; is_sub = 1'b1; m = 5'b11111; end
            5'd5, 5'd21: begin x = f; y = 1; k = 0; m = (op == 5'd5) ? 5'b11111 : 5'b0; end
            5'd6, 5'd22: begin x = f; y = 1; k = 0; is_sub = 1'b1; m = (op == 5'd6) ? 5'b11111 : 5'b0; end
            5'd7:  begin x = 0; y = f; k = 0;       is_sub = 1'b1; m = 5'b11111; end
            default: ;
        endcase
        if (op <= 5'd7 || op == 5'd21 || op == 5'd22) begin
            if (is_sub) begin
                s = x - y - k; lo = (x % 16) - (y % 16) - k; sv = sgn(x) - sgn(y) - k;
                c = (s >= 0); dc = (lo >= 0);
            end else begin
                s = x + y + k; lo = (x % 16) + (y % 16) + k; sv = sgn(x) + sgn(y) + k;
                c = (s > 255); dc = (lo > 15);
            end
            ov = (sv > 127) || (sv < -128);
            r = 8'((s + 512) % 256);
        end else begin
            case (op)
                5'd8:  begin r = w & f; m = 5'b10100; end
                5'd9:  begin r = w | f; m = 5'b10100; end
                5'd10: begin r = w ^ f; m = 5'b10100; end
                5'd11: begin r = ~f;    m = 5'b10100; end
                5'd12: begin r = f;     m = 5'b10100; end
                5'd13: begin r = {f[6:0], cin}; c = f[7]; m = 5'b10101; end
                5'd14: begin r = {cin, f[7:1]}; c = f[0]; m = 5'b10101; end
                5'd15: begin r = {f[6:0], f[7]}; m = 5'b10100; end
                5'd16: begin r = {f[0], f[7:1]}; m = 5'b10100; end
                5'd17: r = {f[3:0], f[7:4]};
                5'd18: r = 8'hFF;
                5'd19: r = w;
                5'd20: begin r = 8'h00; m = 5'b00100; end
                5'd23: begin r = f; r[b] = ~f[b]; end
                5'd24: begin r = f; r[b] = 1'b1; end
                5'd25: begin r = f; r[b] = 1'b0; end
                default: r = f;
            endcase
        end
        cand = {r[7], ov, (r == 8'h00), dc, c};
        fl = (cand & m) | (fl & ~m);
        tofile = dst || op == 5'd7 || op == 5'd18 || op == 5'd19 || op == 5'd20
                 || op == 5'd23 || op == 5'd24 || op == 5'd25;
    endfunction

    task automatic check(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [7:0] r;
        logic tf;
        string tag;
        tag = $sformatf("R%0d", v.rq);
        ref_model(v.op, v.dst, v.bsel, v.w, v.f, v.cin, exp_flags, r, tf);
        @(negedge clk);
        op_valid = 1'b1; op_code = v.op; dest_sel = v.dst; bit_sel = v.bsel;
        wreg_in = v.w; file_in = v.f; carry_in = v.cin;
        @(negedge clk);
        op_valid = 1'b0;
        check(tag, "table result", int'(res_data), int'(v.exp));
        check(tag, "model result", int'(res_data), int'(r));
        check(tag, "flags", int'(flags), int'(exp_flags));
        check(tag, "target", int'(res_to_file), int'(tf));
        check("R10", "valid after one edge", int'(res_valid), 1);
        last_res = r;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11", "reset valid", int'(res_valid), 0);
        check("R11", "reset data", int'(res_data), 0);
        check("R11", "reset target", int'(res_to_file), 0);
        check("R11", "reset flags", int'(flags), 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10: idle cycles with changing inputs leave result and flags alone
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            op_valid = 1'b0; op_code = 5'd0; wreg_in = 8'h11 * j[7:0]; file_in = 8'hC3; carry_in = 1'b1;
            @(negedge clk);
            check("R10", "idle valid", int'(res_valid), 0);
            check("R10", "idle data", int'(res_data), int'(last_res));
            check("R10", "idle flags", int'(flags), int'(exp_flags));
        end

        // R6: clear after arithmetic left C, DC and OV set keeps them
        run_vec('{5'd0, 1'b0, 3'd0, 8'h88, 8'h88, 1'b0, 8'h10, 4'd2});
        run_vec('{5'd20, 1'b1, 3'd0, 8'h00, 8'hAA, 1'b0, 8'h00, 4'd6});
        // R3: logic op leaves arithmetic flags from before
        run_vec('{5'd9, 1'b0, 3'd0, 8'h80, 8'h01, 1'b0, 8'h81, 4'd3});
        // R7: every bit position of toggle
        for (int b = 0; b < 8; b++) begin
            logic [7:0] e;
            e = 8'h00; e[b] = 1'b1;
            run_vec('{5'd23, 1'b0, 3'(b), 8'h00, 8'h00, 1'b0, e, 4'd7});
        end

        // R11: reset wins over an issued operation
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b1; op_code = 5'd18; dest_sel = 1'b1;
        @(negedge clk);
        rst = 1'b0; op_valid = 1'b0;
        check("R11", "reset over op valid", int'(res_valid), 0);
        check("R11", "reset over op data", int'(res_data), 0);
        check("R11", "reset over op flags", int'(flags), 0);
        exp_flags = '0;
        run_vec('{5'd6, 1'b0, 3'd0, 8'h00, 8'h10, 1'b0, 8'h0F, 4'd1});

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule